// File: doc/BRIEF.md
# Predicated integer-to-condition broadcaster

This block runs one vectorised write into a file of 4-bit condition fields. A single start pulse takes in a predicate word, a zeroing enable, a vector length, a 4-bit mask, a 4-bit map, a merge-mode bit and an integer source operand. The block then walks the elements in order, one per clock. Element i targets field base+i and is governed by predicate bit i.

The source is tested through its least significant bit. That bit is copied into all four lanes and then combined with the map and the mask. An element whose predicate bit is clear is either forced to zero (zeroing on) or skipped (zeroing off). The effect is that an integer predicate word is spread across a run of condition fields. Each of those fields holds either the mask-shaped value or zero.

The block owns the field file and shows it at its output. It also shows each write as it happens: a strobe, the field index and the data. A one-cycle done pulse marks the end of the vector.

Top module: `pred_bcast`

## Requirements
- R1: While `rst_n` is low at a clock edge, every field is cleared to 0000. After that edge `busy`, `done` and `wr_en` read 0.
- R2: A `start` seen while idle latches all operands. Element k (k = 0..VL-1) is presented on the write outputs in the (k+1)-th cycle after the start edge and is committed at the end of that cycle. `done` is 1 in the (VL+1)-th cycle. With VL = 0, `done` is 1 in the first cycle and nothing is written.
- R3: Element k writes field (base + k) modulo NFIELDS, governed by predicate bit k. `wr_idx` advances by one, with wraparound, on each element.
- R4: With predicate bit 1, the field becomes ((~map ^ {4{src[0]}}) & mask), ORed with (old & ~mask) when the merge bit is 1. Source bits above bit 0 have no effect.
- R5: With predicate bit 0 and zeroing on, the field is written with 0000 whatever the source, map or merge bit.
- R6: With predicate bit 0 and zeroing off, no write strobe is raised and the field keeps its value.
- R7: With a zero source, predicate 1 and merge 0, the field becomes mask & ~map. For example, mask 0011 with map 0000 gives 0011.
- R8: A `start` while busy is ignored. The running vector completes with its original operands and timing.
- R9: `busy` is high for exactly VL consecutive cycles, and `done` is a single-cycle pulse.
- R10: A VL above MAXVL is treated as MAXVL.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a vector when idle |
| vl | input | $clog2(MAXVL+1) | Vector length |
| base | input | $clog2(NFIELDS) | First target field |
| pred | input | MAXVL | Destination predicate, bit k for element k |
| zero_en | input | 1 | Zero fields whose predicate bit is 0 |
| merge | input | 1 | Keep masked-out bits of the old field |
| fmask | input | 4 | Lane mask |
| fmapv | input | 4 | Lane map (inverting pattern) |
| src | input | XLEN | Integer source; bit 0 is tested |
| busy | output | 1 | Vector in progress |
| done | output | 1 | One-cycle end-of-vector pulse |
| wr_en | output | 1 | A field is written at the end of this cycle |
| wr_idx | output | $clog2(NFIELDS) | Index of the field being written |
| wr_data | output | 4 | Value being written |
| fields | output | 4*NFIELDS | Field file, field j in bits 4j+3:4j |

## Verification
The bench builds the block with MAXVL = 8 and NFIELDS = 8, so a full-length vector covers the whole file. A base of 6 with four elements wraps the index past the last field. A length of 12 reaches the clamp. The field file is small enough to compare in full after every vector, which shows that skipped fields and fields outside the vector are left alone.

// File: rtl/pred_bcast_pkg.sv
// Shared types and the per-lane arithmetic of the broadcaster.
// Assumes 4-bit condition fields; all other sizes are parameters of the top.
package pred_bcast_pkg;

    typedef logic [3:0] field_t;

    // Masked test of a broadcast source bit, optionally merged with the old field.
    function automatic field_t masked_test(input field_t msk, input field_t mapv,
                                           input logic srcbit, input logic mrg,
                                           input field_t old);
        field_t t;
        t = (~mapv ^ {4{srcbit}}) & msk;
        if (mrg)
            t = t | (old & ~msk);
        return t;
    endfunction

endpackage

// File: rtl/pb_seq.sv
// Element sequencer: accepts a start when idle, clamps VL, steps one element
// per clock and raises a one-cycle done pulse after the last element.
// Assumes MAXVL >= 2.
module pb_seq #(
    parameter int MAXVL = 8,
    localparam int VLW = $clog2(MAXVL + 1),
    localparam int CW  = $clog2(MAXVL)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [VLW-1:0] vl,
    output logic           accept,
    output logic           busy,
    output logic           done,
    output logic [CW-1:0]  elem
);
    logic [VLW-1:0] vl_eff;
    logic [VLW-1:0] vl_q;
    logic           last;

    // Clamp the requested length to the supported maximum.
    always_comb vl_eff = (vl > VLW'(MAXVL)) ? VLW'(MAXVL) : vl;

    assign accept = start && !busy;
    assign last   = (VLW'(elem) + VLW'(1)) == vl_q;

    // Step through elements and generate busy and done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            done <= 1'b0;
            elem <= '0;
            vl_q <= '0;
        end else begin
            done <= 1'b0;
            if (accept) begin
                vl_q <= vl_eff;
                elem <= '0;
                if (vl_eff == '0)
                    done <= 1'b1;
                else
                    busy <= 1'b1;
            end else if (busy) begin
                if (last) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                    elem <= '0;
                end else begin
                    elem <= elem + CW'(1);
                end
            end
        end
    end
endmodule

// File: rtl/pb_calc.sv
// Per-element write decision: predicate, zeroing and masked test combined
// into a write strobe and a 4-bit value. Purely combinational.
module pb_calc
    import pred_bcast_pkg::*;
(
    input  logic   active,
    input  logic   pbit,
    input  logic   zero_q,
    input  logic   merge_q,
    input  field_t mask_q,
    input  field_t map_q,
    input  logic   srcbit_q,
    input  field_t old,
    output logic   we,
    output field_t wdata
);
    // Choose between the masked test, a zeroing write and no write.
    always_comb begin
        we    = 1'b0;
        wdata = '0;
        if (active) begin
            if (pbit) begin
                we    = 1'b1;
                wdata = masked_test(mask_q, map_q, srcbit_q, merge_q, old);
            end else if (zero_q) begin
                we    = 1'b1;
                wdata = '0;
            end
        end
    end
endmodule

// File: rtl/pb_file.sv
// Condition field file: NFIELDS 4-bit registers with one write port and one
// combinational read port, plus a flattened view of all fields.
// Assumes NFIELDS is a power of two.
module pb_file
    import pred_bcast_pkg::*;
#(
    parameter int NFIELDS = 16,
    localparam int IW = $clog2(NFIELDS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we,
    input  logic [IW-1:0]        widx,
    input  field_t               wdata,
    input  logic [IW-1:0]        ridx,
    output field_t               rdata,
    output logic [4*NFIELDS-1:0] flat
);
    field_t regs [NFIELDS];

    for (genvar g = 0; g < NFIELDS; g++) begin : g_field
        // Hold or replace field g.
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs[g] <= '0;
            else if (we && widx == IW'(g))
                regs[g] <= wdata;
        end
        assign flat[4*g +: 4] = regs[g];
    end

    assign rdata = regs[ridx];
endmodule

// File: rtl/pred_bcast.sv
// Top of the predicated integer-to-condition broadcaster. Latches operands on
// an accepted start, then writes one field per clock from base upward.
// Assumes NFIELDS is a power of two (index wraps) and MAXVL >= 2.
module pred_bcast
    import pred_bcast_pkg::*;
#(
    parameter int XLEN    = 64,
    parameter int MAXVL   = 8,
    parameter int NFIELDS = 16,
    localparam int VLW = $clog2(MAXVL + 1),
    localparam int IW  = $clog2(NFIELDS),
    localparam int CW  = $clog2(MAXVL)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [VLW-1:0]       vl,
    input  logic [IW-1:0]        base,
    input  logic [MAXVL-1:0]     pred,
    input  logic                 zero_en,
    input  logic                 merge,
    input  logic [3:0]           fmask,
    input  logic [3:0]           fmapv,
    input  logic [XLEN-1:0]      src,
    output logic                 busy,
    output logic                 done,
    output logic                 wr_en,
    output logic [IW-1:0]        wr_idx,
    output logic [3:0]           wr_data,
    output logic [4*NFIELDS-1:0] fields
);
    logic             accept;
    logic [CW-1:0]    elem;
    logic [IW-1:0]    base_q;
    logic [MAXVL-1:0] pred_q;
    logic             zero_q, merge_q, srcbit_q;
    field_t           mask_q, map_q, old;
    logic             cur_pred;
    logic             unused_src_hi;

    assign unused_src_hi = ^src[XLEN-1:1];

    pb_seq #(.MAXVL(MAXVL)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .vl(vl),
        .accept(accept), .busy(busy), .done(done), .elem(elem)
    );

    // Capture the operands of an accepted vector.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q   <= '0;
            pred_q   <= '0;
            zero_q   <= 1'b0;
            merge_q  <= 1'b0;
            mask_q   <= '0;
            map_q    <= '0;
            srcbit_q <= 1'b0;
        end else if (accept) begin
            base_q   <= base;
            pred_q   <= pred;
            zero_q   <= zero_en;
            merge_q  <= merge;
            mask_q   <= fmask;
            map_q    <= fmapv;
            srcbit_q <= src[0];
        end
    end

    assign wr_idx   = base_q + IW'(elem);
    assign cur_pred = pred_q[elem];

    pb_calc u_calc (
        .active(busy), .pbit(cur_pred), .zero_q(zero_q), .merge_q(merge_q),
        .mask_q(mask_q), .map_q(map_q), .srcbit_q(srcbit_q), .old(old),
        .we(wr_en), .wdata(wr_data)
    );

    pb_file #(.NFIELDS(NFIELDS)) u_file (
        .clk(clk), .rst_n(rst_n), .we(wr_en), .widx(wr_idx), .wdata(wr_data),
        .ridx(wr_idx), .rdata(old), .flat(fields)
    );
endmodule

// File: rtl/pred_bcast_chk.sv
// Property checker for pred_bcast, attached to every instance by bind.
module pred_bcast_chk #(
    parameter int NFIELDS = 16,
    localparam int IW = $clog2(NFIELDS)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 start,
    input logic                 busy,
    input logic                 done,
    input logic                 wr_en,
    input logic [IW-1:0]        wr_idx,
    input logic [3:0]           wr_data,
    input logic                 cur_pred,
    input logic [4*NFIELDS-1:0] fields
);
    logic          prev_en;
    logic [IW-1:0] prev_idx;
    logic [3:0]    prev_data;

    // Remember the last write so its commit can be checked.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_en   <= 1'b0;
            prev_idx  <= '0;
            prev_data <= '0;
        end else begin
            prev_en   <= wr_en;
            prev_idx  <= wr_idx;
            prev_data <= wr_data;
        end
    end

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !wr_en);
    assert_idle_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> (busy || done));
    assert_zeroing_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !cur_pred) |-> (wr_data == 4'b0000));
    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(fields));
    assert_commit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        prev_en |-> (fields[prev_idx*4 +: 4] == prev_data));
    assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (!busy || wr_idx == IW'($past(wr_idx) + 1'b1)));
endmodule

bind pred_bcast pred_bcast_chk #(.NFIELDS(NFIELDS)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .cur_pred(cur_pred),
    .fields(fields)
);

// File: tb/sim_pred_bcast.sv
module sim_pred_bcast;
    localparam int CLK_PERIOD = 10;
    localparam int XLEN = 64;
    localparam int MAXVL = 8;
    localparam int NF = 8;
    localparam int VLW = $clog2(MAXVL + 1);
    localparam int IW = $clog2(NF);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [VLW-1:0] vl = '0;
    logic [IW-1:0] base = '0;
    logic [MAXVL-1:0] pred = '0;
    logic zero_en = 1'b0, merge = 1'b0;
    logic [3:0] fmask = '0, fmapv = '0;
    logic [XLEN-1:0] src = '0;
    logic busy, done, wr_en;
    logic [IW-1:0] wr_idx;
    logic [3:0] wr_data;
    logic [4*NF-1:0] fields;

    int n_tests = 0;
    int n_fail = 0;
    int cycles = 0;
    logic [3:0] model [NF];

    pred_bcast #(.XLEN(XLEN), .MAXVL(MAXVL), .NFIELDS(NF)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .vl(vl), .base(base),
        .pred(pred), .zero_en(zero_en), .merge(merge), .fmask(fmask),
        .fmapv(fmapv), .src(src), .busy(busy), .done(done), .wr_en(wr_en),
        .wr_idx(wr_idx), .wr_data(wr_data), .fields(fields)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: run hung, act=%0d exp=<100000", cycles);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    task automatic chk(input logic ok, input string req, input string what,
                       input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: act=%0h exp=%0h", req, what, act, exp);
        end
    endtask

    task automatic check_file(input string req);
        for (int j = 0; j < NF; j++)
            chk(fields[4*j +: 4] == model[j], req, $sformatf("field %0d", j),
                fields[4*j +: 4], model[j]);
    endtask

    // Run one vector and check every element cycle, done timing and the file.
    // intrude: pulse start with other operands in the second element cycle.
    task automatic run_op(input int b, input int v, input logic [MAXVL-1:0] p,
                          input logic z, input logic m, input logic [3:0] mk,
                          input logic [3:0] mp, input logic [XLEN-1:0] s,
                          input logic intrude, input string req);
        int ve;
        int idx;
        logic [3:0] e;
        logic sb;
        ve = (v > MAXVL) ? MAXVL : v;
        sb = s[0];
        @(negedge clk);
        start = 1'b1; vl = VLW'(v); base = IW'(b); pred = p; zero_en = z;
        merge = m; fmask = mk; fmapv = mp; src = s;
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k < ve; k++) begin
            idx = (b + k) % NF;
            chk(busy == 1'b1, "R9", "busy during element", busy, 1);
            chk(done == 1'b0, "R2", "done early", done, 0);
            chk(wr_idx == IW'(idx), "R3", "wr_idx", wr_idx, idx);
            if (p[k]) begin
                e = (~mp ^ {4{sb}}) & mk;
                if (m) e = e | (model[idx] & ~mk);
                chk(wr_en == 1'b1, req, "wr_en pred on", wr_en, 1);
                chk(wr_data == e, req, "wr_data pred on", wr_data, e);
                model[idx] = e;
            end else if (z) begin
                chk(wr_en == 1'b1, "R5", "wr_en zeroing", wr_en, 1);
                chk(wr_data == 4'b0000, "R5", "wr_data zeroing", wr_data, 0);
                model[idx] = 4'b0000;
            end else begin
                chk(wr_en == 1'b0, "R6", "wr_en skipped", wr_en, 0);
            end
            if (intrude && k == 0) begin
                start = 1'b1; base = IW'(b + 3); pred = ~p; zero_en = ~z;
                fmask = ~mk; src = ~s; vl = VLW'(1);
            end
            @(negedge clk);
            start = 1'b0;
        end
        chk(done == 1'b1, "R2", "done at VL+1", done, 1);
        chk(busy == 1'b0, "R9", "busy after vector", busy, 0);
        chk(wr_en == 1'b0, "R2", "no write after vector", wr_en, 0);
        check_file(req);
        @(negedge clk);
        chk(done == 1'b0, "R9", "done single pulse", done, 0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int j = 0; j < NF; j++) model[j] = 4'b0000;
        chk(busy == 1'b0, "R1", "busy after reset", busy, 0);
        chk(done == 1'b0, "R1", "done after reset", done, 0);
        chk(wr_en == 1'b0, "R1", "wr_en after reset", wr_en, 0);
        check_file("R1");
    endtask

    task automatic t_zero_source();  // R7: mask 0011, map 0000 gives 0011
        run_op(0, 2, 8'b11, 1'b0, 1'b0, 4'b0011, 4'b0000, '0, 1'b0, "R7");
        chk(fields[3:0] == 4'b0011, "R7", "field0 equals mask", fields[3:0], 4'b0011);
        run_op(4, 1, 8'b1, 1'b0, 1'b0, 4'b1110, 4'b0110, '0, 1'b0, "R7");
    endtask

    task automatic t_zeroing();  // R5: field 0 forced to 0000, field 1 written
        run_op(0, 2, 8'b10, 1'b1, 1'b0, 4'b0011, 4'b0000, '0, 1'b0, "R5");
        run_op(0, 4, 8'b0000, 1'b1, 1'b1, 4'b1111, 4'b0000, 64'h1, 1'b0, "R5");
    endtask

    task automatic t_skip();  // R6: predicate-off fields untouched
        run_op(0, 8, 8'hFF, 1'b0, 1'b0, 4'b1111, 4'b0000, 64'h1, 1'b0, "R4");
        run_op(0, 8, 8'b0101_0101, 1'b0, 1'b0, 4'b1111, 4'b1111, 64'h1, 1'b0, "R6");
    endtask

    task automatic t_merge();  // R4: merge keeps masked-out bits; high src bits ignored
        run_op(1, 3, 8'b111, 1'b0, 1'b1, 4'b0101, 4'b0001, 64'h1, 1'b0, "R4");
        run_op(1, 3, 8'b111, 1'b0, 1'b1, 4'b1010, 4'b1000, 64'hFFFF_FFFF_FFFF_FFFE, 1'b0, "R4");
        run_op(2, 2, 8'b11, 1'b0, 1'b0, 4'b1100, 4'b0100, 64'hFFFF_FFFF_FFFF_FFFE, 1'b0, "R4");
    endtask

    task automatic t_wrap();  // R3: base 6, four elements wrap to 0 and 1
        run_op(6, 4, 8'b1011, 1'b1, 1'b0, 4'b1001, 4'b0000, '0, 1'b0, "R3");
    endtask

    task automatic t_vl_zero();  // R2: done in first cycle, no writes
        run_op(3, 0, 8'hFF, 1'b1, 1'b0, 4'b1111, 4'b0000, '0, 1'b0, "R2");
    endtask

    task automatic t_clamp();  // R10: VL 12 behaves as 8
        run_op(5, 12, 8'b1100_1010, 1'b1, 1'b0, 4'b0110, 4'b0010, 64'h1, 1'b0, "R10");
    endtask

    task automatic t_busy_start();  // R8: start during a vector ignored
        run_op(2, 4, 8'b0110, 1'b0, 1'b0, 4'b0111, 4'b0001, '0, 1'b1, "R8");
    endtask

    initial begin
        t_reset();
        t_zero_source();
        t_zeroing();
        t_skip();
        t_merge();
        t_wrap();
        t_vl_zero();
        t_clamp();
        t_busy_start();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule